// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block is the interrupt front end for a bank of general-purpose input pins. Each pin has its own interrupt configuration word, a one-bit interrupt status flag and a read-only view of its input level. All of these sit behind a single-cycle register port. Every pin input passes through a two-flop synchronizer. The synchronized value is compared with its previous sample to find edges, or with the configured polarity to find an active level. A qualifying event latches the pin's status flag. The status flags of enabled pins are ORed into one summary interrupt for the parent interrupt controller.

Two configuration encodings are offered, chosen per instance by parameter. The first has a 2-bit detection field with native detection of both edges. The second has a 1-bit detection field, where the polarity bit chooses which edge is detected. A raw-status enable bit gates all event latching. Setting that bit on a pin configured for edges also produces one spurious event; real silicon shows this artefact and the block copies it. Software clears a flag by writing its status register. Each pin has its own acknowledge sense: for some pins, writing 1 clears the flag; for others, writing 0 does.

Register address = {pin index, select}. The select values are: 0 for the configuration word, 1 for status (bit 0), 2 for the synchronized input (bit 0), and 3, which reads zero. Configuration word fields: bit 0 is interrupt enable; bit 1 is raw-status enable; bits 3:2 are the detection field; bit 4 is polarity; bits 7:5 are the routing target. The target field is stored and read back only; value 4 stands for the application processor.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration word reads 0, every status bit reads 0 and irq_o is low.
- R2: A pin input change appears at select 2 after exactly two rising clock edges (value still old after one edge), whatever the interrupt configuration.
- R3: With the 2-bit encoding, detection code 1 latches status on a rising edge, code 2 on a falling edge and code 3 on either edge; polarity has no effect in these codes.
- R4: With the 1-bit encoding, detection bit 2 set selects edge mode: polarity 1 latches on a rising edge, polarity 0 on a falling edge; bit 3 is not stored and reads 0.
- R5: With a detection field of zero the pin is level sensitive (polarity 1 active-high, polarity 0 active-low). Status stays set while the active level persists, even across an acknowledge.
- R6: While raw-status enable (bit 1) is 0, no event of any kind sets the status bit.
- R7: A write that takes raw-status enable from 0 to 1 on a pin whose detection field selects edge mode sets that pin's status bit one cycle later, with no pin activity; for a level-mode pin with an inactive input it does not.
- R8: irq_o is high exactly when some pin has its status bit set and its interrupt enable (bit 0) set.
- R9: Writing select 1 with bit 0 equal to the pin's ACK_HIGH bit clears its status bit; writing the opposite value leaves it unchanged.
- R10: When an event and an acknowledge for the same pin fall in the same cycle, the status bit stays set.
- R11: The configuration word reads back as written, including the 3-bit target field (for example target 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | PIN_W+2 | Register address {pin index, select} |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from address) |
| irq_o | output | 1 | Summary interrupt to the parent controller |

## Verification
The bench builds two instances, each with four pins and an acknowledge mask of 4'b0101. One instance uses the 2-bit detection encoding and the other the 1-bit encoding. This small size allows a full sweep over every detection code, both polarities and all four start/end pin-level pairs on every pin of both instances. In that sweep the expected status bit is computed arithmetically from the mode. Directed sequences then time an acknowledge into the same cycle as an edge. They also toggle the raw-status enable, and exercise both acknowledge senses and the enable masking of the summary interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W = 8;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IO   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] target;
        logic       pol;
        logic [1:0] det;
        logic       raw_en;
        logic       en;
    } irq_cfg_t;

    // Drop the upper detection bit when the instance uses the narrow encoding.
    function automatic irq_cfg_t cfg_from_word(logic [CFG_W-1:0] w, int det_w);
        irq_cfg_t c;
        c = irq_cfg_t'(w);
        if (det_w == 1) c.det[1] = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic s_o,
    output logic prev_o
);
    logic meta_q, s_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            s_q    <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= d_i;
            s_q    <= meta_q;
            prev_q <= s_q;
        end
    end

    assign s_o    = s_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int DET_W = 2
) (
    input  logic [1:0] det,
    input  logic       pol,
    input  logic       s,
    input  logic       prev,
    output logic       hit,
    output logic       edge_mode
);
    logic rise, fall, level_hit;

    assign rise      = s & ~prev;
    assign fall      = ~s & prev;
    assign level_hit = (s == pol);
    assign edge_mode = |det;

    generate
        if (DET_W == 2) begin : g_wide
            // code 1 rising, 2 falling, 3 both; polarity unused for edges
            assign hit = edge_mode ? ((det[0] & rise) | (det[1] & fall)) : level_hit;
        end else begin : g_narrow
            // single edge, polarity chooses its direction
            assign hit = edge_mode ? (pol ? rise : fall) : level_hit;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter int   DET_W    = 2,
    parameter logic ACK_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             stat_we,
    output irq_cfg_t         cfg_o,
    output logic             status_o,
    output logic             sync_o
);
    irq_cfg_t cfg_q;
    logic     status_q, raw_prev_q;
    logic     s, prev, hit, edge_mode, spurious, evt, ack;

    gpio_irq_sync i_sync (
        .clk   (clk),
        .rst   (rst),
        .d_i   (pin_i),
        .s_o   (s),
        .prev_o(prev)
    );

    gpio_irq_detect #(.DET_W(DET_W)) i_det (
        .det      (cfg_q.det),
        .pol      (cfg_q.pol),
        .s        (s),
        .prev     (prev),
        .hit      (hit),
        .edge_mode(edge_mode)
    );

    assign spurious = cfg_q.raw_en & ~raw_prev_q & edge_mode;
    assign evt      = cfg_q.raw_en & (hit | spurious);
    assign ack      = stat_we & (wdata[0] == ACK_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            status_q   <= 1'b0;
            raw_prev_q <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= cfg_from_word(wdata, DET_W);
            raw_prev_q <= cfg_q.raw_en;
            status_q   <= evt | (status_q & ~ack);
        end
    end

    assign cfg_o    = cfg_q;
    assign status_o = status_q;
    assign sync_o   = s;

    // R10
    evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && ack) |=> status_q);
    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !evt) |=> !status_q);
    // R6
    raw_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.raw_en && !status_q) |=> !status_q);
    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && cfg_q.raw_en && (s == cfg_q.pol)) |=> status_q);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter int               DET_W    = 2,
    parameter logic [NPINS-1:0] ACK_HIGH = '1,
    localparam int              PIN_W    = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int              AW       = PIN_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_i,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CFG_W-1:0] bus_wdata,
    output logic [CFG_W-1:0] bus_rdata,
    output logic             irq_o
);
    reg_sel_e         sel;
    logic [PIN_W-1:0] pin_idx;
    irq_cfg_t         cfg_arr [NPINS];
    logic [NPINS-1:0] stat_vec, sync_vec, en_vec;

    assign sel     = reg_sel_e'(bus_addr[1:0]);
    assign pin_idx = bus_addr[AW-1:2];

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            logic hit_addr;
            assign hit_addr = bus_we && (pin_idx == PIN_W'(i));

            gpio_irq_pin #(.DET_W(DET_W), .ACK_HIGH(ACK_HIGH[i])) i_pin (
                .clk     (clk),
                .rst     (rst),
                .pin_i   (pins_i[i]),
                .cfg_we  (hit_addr && (sel == SEL_CFG)),
                .wdata   (bus_wdata),
                .stat_we (hit_addr && (sel == SEL_STAT)),
                .cfg_o   (cfg_arr[i]),
                .status_o(stat_vec[i]),
                .sync_o  (sync_vec[i])
            );
            assign en_vec[i] = cfg_arr[i].en;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (pin_idx == PIN_W'(i)) begin
                case (sel)
                    SEL_CFG:  bus_rdata = cfg_arr[i];
                    SEL_STAT: bus_rdata = {{(CFG_W-1){1'b0}}, stat_vec[i]};
                    SEL_IO:   bus_rdata = {{(CFG_W-1){1'b0}}, sync_vec[i]};
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq_o = |(stat_vec & en_vec);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !irq_o);
endmodule

// File: tb/test_gpio_irq_unit.sv
module test_gpio_irq_unit;
    localparam int NP = 4;
    localparam logic [NP-1:0] ACKM = 4'b0101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins_a = '0, pins_b = '0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_a, rdata_b;
    logic       irq_a, irq_b;
    int         dsel = 0;
    int         checks = 0, failures = 0;

    always #5 clk = ~clk;

    gpio_irq_unit #(.NPINS(NP), .DET_W(2), .ACK_HIGH(ACKM)) i_gpio_irq_unit (
        .clk(clk), .rst(rst), .pins_i(pins_a), .bus_we(we && dsel == 0),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_a), .irq_o(irq_a));

    gpio_irq_unit #(.NPINS(NP), .DET_W(1), .ACK_HIGH(ACKM)) i_gpio_irq_unit_n (
        .clk(clk), .rst(rst), .pins_i(pins_b), .bus_we(we && dsel == 1),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_o(irq_b));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ra(int pin, int s);
        return {2'(pin), 2'(s)};
    endfunction

    task automatic wr(logic [3:0] a, logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = (dsel == 0) ? rdata_a : rdata_b;
    endtask

    task automatic setpin(int pin, logic v);
        if (dsel == 0) pins_a[pin] = v; else pins_b[pin] = v;
    endtask

    task automatic trial(string req, int pin, int det, int pol, int from, int to);
        logic [7:0] v;
        int lvl, rs, fs, exp;
        setpin(pin, 1'(from));
        wr(ra(pin, 0), {3'd4, 1'(pol), 2'(det), 1'b1, 1'b1});
        repeat (4) @(negedge clk);
        wr(ra(pin, 1), {7'd0, ACKM[pin]});
        setpin(pin, 1'(to));
        repeat (3) @(negedge clk);
        rd(ra(pin, 1), v);
        lvl = (det == 0);
        if (dsel == 0) begin rs = det & 1; fs = (det >> 1) & 1; end
        else begin rs = pol; fs = !pol; end
        if (lvl) exp = (from == pol) || (to == pol);
        else exp = (from != to) && ((to == 1 && rs == 1) || (to == 0 && fs == 1));
        chk(req, int'(v[0]), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state on both instances
        for (int d = 0; d < 2; d++) begin
            dsel = d;
            for (int p = 0; p < NP; p++) begin
                rd(ra(p, 0), v); chk("R1 cfg", v, 0);
                rd(ra(p, 1), v); chk("R1 status", v, 0);
            end
        end
        chk("R1 irq_a", irq_a, 0);
        chk("R1 irq_b", irq_b, 0);

        // R2 input visible after two edges
        dsel = 1;
        @(negedge clk);
        pins_b[3] = 1'b1;
        @(negedge clk);
        rd(ra(3, 2), v); chk("R2 one edge", v, 0);
        @(negedge clk);
        rd(ra(3, 2), v); chk("R2 two edges", v, 1);
        pins_b[3] = 1'b0;
        repeat (3) @(negedge clk);

        // R11 readback of config, target field = 4
        dsel = 0;
        wr(ra(2, 0), 8'h8B); rd(ra(2, 0), v); chk("R11 wide readback", v, 8'h8B);
        wr(ra(2, 0), 8'hA5); rd(ra(2, 0), v); chk("R11 wide readback", v, 8'hA5);
        dsel = 1;
        wr(ra(2, 0), 8'h8B); rd(ra(2, 0), v); chk("R4 narrow bit3 masked", v, 8'h83);
        wr(ra(2, 0), 8'h00);
        dsel = 0;
        wr(ra(2, 0), 8'h00);
        repeat (3) @(negedge clk);

        // R3/R5 sweep on the 2-bit encoding
        dsel = 0;
        for (int p = 0; p < NP; p++)
            for (int det = 0; det < 4; det++)
                for (int pol = 0; pol < 2; pol++)
                    for (int f = 0; f < 2; f++)
                        for (int t = 0; t < 2; t++)
                            trial(det == 0 ? "R5 wide level" : "R3 wide edge", p, det, pol, f, t);

        // R4/R5 sweep on the 1-bit encoding
        dsel = 1;
        for (int p = 0; p < NP; p++)
            for (int det = 0; det < 2; det++)
                for (int pol = 0; pol < 2; pol++)
                    for (int f = 0; f < 2; f++)
                        for (int t = 0; t < 2; t++)
                            trial(det == 0 ? "R5 narrow level" : "R4 narrow edge", p, det, pol, f, t);

        // quiet state on the wide instance
        dsel = 0;
        pins_a = '0;
        for (int p = 0; p < NP; p++) wr(ra(p, 0), 8'h00);
        repeat (4) @(negedge clk);
        for (int p = 0; p < NP; p++) wr(ra(p, 1), {7'd0, ACKM[p]});
        @(negedge clk);
        chk("R8 irq quiet", irq_a, 0);

        // R7 spurious on raw enable rise, edge mode; R8 masked by enable
        wr(ra(2, 0), 8'h06);
        @(negedge clk);
        rd(ra(2, 1), v); chk("R7 spurious set", v, 1);
        chk("R8 irq masked", irq_a, 0);
        wr(ra(2, 0), 8'h07);
        chk("R8 irq enabled", irq_a, 1);
        wr(ra(2, 1), 8'h01);
        rd(ra(2, 1), v); chk("R9 ack-high clear", v, 0);
        chk("R8 irq after ack", irq_a, 0);

        // R7 level pin, inactive input: no spurious
        wr(ra(1, 0), 8'h12);
        @(negedge clk);
        rd(ra(1, 1), v); chk("R7 level no spurious", v, 0);

        // R6 raw enable off blocks edges
        wr(ra(3, 0), 8'h0D);
        pins_a[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(3, 1), v); chk("R6 gated rise", v, 0);
        pins_a[3] = 1'b0;
        repeat (3) @(negedge clk);
        rd(ra(3, 1), v); chk("R6 gated fall", v, 0);
        chk("R6 irq", irq_a, 0);

        // R9 ack-high pin 0
        wr(ra(0, 0), 8'h0F);
        @(negedge clk);
        wr(ra(0, 1), 8'h00);
        rd(ra(0, 1), v); chk("R9 wrong sense keeps", v, 1);
        wr(ra(0, 1), 8'h01);
        rd(ra(0, 1), v); chk("R9 ack-high clears", v, 0);

        // R9 ack-low pin 1
        wr(ra(1, 0), 8'h0E);
        pins_a[1] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(1, 1), v); chk("R3 both-edge rise", v, 1);
        wr(ra(1, 1), 8'h01);
        rd(ra(1, 1), v); chk("R9 wrong sense keeps", v, 1);
        wr(ra(1, 1), 8'h00);
        rd(ra(1, 1), v); chk("R9 ack-low clears", v, 0);

        // R10 edge and ack in the same cycle
        pins_a[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(ra(0, 1), v); chk("R10 pre set", v, 1);
        pins_a[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr(ra(0, 1), 8'h01);
        rd(ra(0, 1), v); chk("R10 event wins", v, 1);
        wr(ra(0, 1), 8'h01);
        rd(ra(0, 1), v); chk("R10 later ack clears", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule